// File: doc/BRIEF.md
# External bus cycle controller

This block is the master side of a narrow external memory bus. A requester hands it one request: an address, a read or write flag, an operand size (byte, half-word, word or 16-byte line), the width of the external port (8, 16 or 32 bits) and a burst enable. The controller splits the operand into as many beats as the port width requires. It drives chip select, a per-beat address, a two-bit size code, an active-low burst flag and the write data. It then waits for each beat to be acknowledged.

A beat ends on an acknowledge. The acknowledge comes from the external active-low input, or from an internal counter once a programmed number of wait states has elapsed. When the internal counter is enabled, an external acknowledge still ends the beat early. Read bytes are captured at each acknowledge and assembled into a line. After the final beat the block returns a one-cycle done pulse carrying the assembled read data. It serves one chip-select region, which has a valid bit, an auto-acknowledge enable and a wait-state count.

Top module: `xbus_master`

## Requirements
- R1: After reset, `bus_cs_no` and `bus_tbst_no` are high, and `bus_wdata_oe_o`, `busy_o` and `done_o` are low.
- R2: The beat count is the operand byte count divided by the port byte count, with a minimum of one. Operand codes are 01 = 1 byte, 10 = 2, 00 = 4 and 11 = 16. Port codes are 01 = 8-bit, 10 = 16-bit, and 00 or 11 = 32-bit. Beat k addresses `(A & ~M) | ((A + k*P) & M)`, where A is the request address, P is the port byte count and M is the operand byte count minus one. A misaligned line therefore wraps inside its 16-byte block.
- R3: Without a burst, the first beat shows the operand size code on `bus_tsiz_o`. Each later beat shows the port code: 01 for 8-bit, 10 for 16-bit, 00 for 32-bit.
- R4: With the burst enable set and more than one beat, `bus_tbst_no` is low for every beat and `bus_tsiz_o` holds the operand code throughout. A single-beat transfer never lowers `bus_tbst_no`.
- R5: With auto-acknowledge off, a beat ends only at a clock edge where `bus_ta_ni` is low while chip select is active.
- R6: With auto-acknowledge on and wait count W, a beat ends at the (W+1)th clock of the beat, or earlier at any edge where `bus_ta_ni` is low.
- R7: A low `bus_ta_ni` while `bus_cs_no` is high has no effect: no chip select, no busy and no done.
- R8: At each read acknowledge, port lane j (bits 8j+7:8j, for j below min(P, operand bytes)) is stored as operand byte `((A + k*P) & M) + j`. `done_rdata_o` gives byte i in bits 8i+7:8i and is zero above the operand size.
- R9: `bus_cs_no` rises in the clock after the final acknowledge. `done_o` is high for exactly that one clock.
- R10: On a write, `bus_wdata_oe_o` is high during every beat and for one clock after `bus_cs_no` rises. Beat k drives operand bytes starting at `(A + k*P) & M` on the low lanes, and unused lanes are zero.
- R11: While `cfg_valid_i` is low, a request is dropped and the block stays idle with chip select inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Region enable |
| cfg_aa_en_i | input | 1 | Internal acknowledge enable |
| cfg_ws_i | input | WS_W | Wait states before the internal acknowledge |
| req_i | input | 1 | Request strobe, taken when idle |
| req_wr_i | input | 1 | 1 = write |
| req_size_i | input | 2 | Operand size code |
| req_port_i | input | 2 | Port width code |
| req_burst_i | input | 1 | Burst enable |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | 128 | Write operand, byte i in bits 8i+7:8i |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_rdata_o | output | 128 | Assembled read operand |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_addr_o | output | AW | Beat address |
| bus_tsiz_o | output | 2 | Size code |
| bus_tbst_no | output | 1 | Burst flag, active low |
| bus_wdata_o | output | 32 | Write data lanes |
| bus_wdata_oe_o | output | 1 | Write data drive enable |
| bus_rdata_i | input | 32 | Read data lanes |
| bus_ta_ni | input | 1 | External acknowledge, active low |

## Verification
The bench targets the size-code sequence on an 8-bit port, both with and without a burst. A design that confused the two modes would show 01 on a burst beat, or 00 on a later single beat. It runs a misaligned line with a late external acknowledge and a short wait count combined with an early external acknowledge. A wrong wrap or a wrong acknowledge rule shows up as a wrong address, or as a beat that lasts one clock too long or too short. It drives a stray acknowledge while idle and issues a request with the region disabled, which would expose a block that starts a cycle anyway. It also checks that write data stays driven for exactly one clock after chip select rises.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LINE_B = 16;
  localparam int PORT_B = 4;
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int OP_W   = OFF_W + 1;
  localparam int BEAT_W = OFF_W + 1;
  localparam int LANE_W = $clog2(PORT_B) + 1;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;
  localparam logic [1:0] SZ_LINE = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_HOLD} xbus_st_e;

  function automatic logic [OP_W-1:0] op_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: op_bytes = OP_W'(1);
      SZ_HALF: op_bytes = OP_W'(2);
      SZ_LINE: op_bytes = OP_W'(LINE_B);
      default: op_bytes = OP_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/xbus_beat_plan.sv
module xbus_beat_plan
  import xbus_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     base_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        port_i,
  input  logic              burst_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              last_o,
  output logic              burst_on_o,
  output logic [1:0]        tsiz_o,
  output logic [AW-1:0]     addr_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [LANE_W-1:0] lane_b_o,
  output logic [OP_W-1:0]   op_b_o
);
  logic [1:0]        pshift, pcode;
  logic [OP_W-1:0]   ob, pb;
  logic [BEAT_W-1:0] nb;
  logic [AW-1:0]     sum, mask;

  always_comb begin
    case (port_i)
      2'b01:   begin pshift = 2'd0; pcode = SZ_BYTE; end
      2'b10:   begin pshift = 2'd1; pcode = SZ_HALF; end
      default: begin pshift = 2'd2; pcode = SZ_LONG; end
    endcase
    ob   = op_bytes(size_i);
    pb   = OP_W'(1) << pshift;
    nb   = (ob > pb) ? BEAT_W'(ob >> pshift) : BEAT_W'(1);
    sum  = base_i + (AW'(beat_i) << pshift);
    mask = AW'(ob) - AW'(1);
  end

  assign op_b_o     = ob;
  assign last_o     = (beat_i == nb - BEAT_W'(1));
  assign burst_on_o = burst_i && (nb > BEAT_W'(1));
  // burst keeps the operand code; otherwise only the first beat shows it
  assign tsiz_o     = (burst_on_o || beat_i == '0) ? size_i : pcode;
  assign addr_o     = (base_i & ~mask) | (sum & mask);
  assign off_o      = sum[OFF_W-1:0] & mask[OFF_W-1:0];
  assign lane_b_o   = (ob < pb) ? LANE_W'(ob) : LANE_W'(pb);
endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beat_i,
  input  logic            aa_en_i,
  input  logic [WS_W-1:0] ws_i,
  input  logic            ta_ni,
  output logic            ack_o
);
  logic [WS_W-1:0] cnt_q;

  // external ack only counts while a beat is open
  assign ack_o = beat_i && (!ta_ni || (aa_en_i && cnt_q == ws_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!beat_i || ack_o) cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + WS_W'(1);
  end
endmodule

// File: rtl/xbus_data_path.sv
module xbus_data_path
  import xbus_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                cap_i,
  input  logic [LINE_B*8-1:0] wline_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [LANE_W-1:0]   lane_b_i,
  input  logic [OP_W-1:0]     op_b_i,
  input  logic [PORT_B*8-1:0] rdata_i,
  output logic [PORT_B*8-1:0] wdata_o,
  output logic [LINE_B*8-1:0] line_o
);
  localparam int LS = $clog2(PORT_B);

  logic [PORT_B*8-1:0] wsel;
  assign wsel = (PORT_B*8)'(wline_i >> {off_i, 3'b000});

  for (genvar j = 0; j < PORT_B; j++) begin : g_wlane
    assign wdata_o[j*8 +: 8] = (LANE_W'(j) < lane_b_i) ? wsel[j*8 +: 8] : 8'h00;
  end

  for (genvar i = 0; i < LINE_B; i++) begin : g_rbyte
    localparam logic [OP_W-1:0] IDX = OP_W'(i);
    logic [OP_W-1:0] rel;
    logic            hit;
    logic [7:0]      byte_q;

    assign rel = IDX - {1'b0, off_i};
    assign hit = cap_i && (IDX >= {1'b0, off_i}) && (rel < OP_W'(lane_b_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= 8'h00;
      else if (clr_i) byte_q <= 8'h00;
      else if (hit)   byte_q <= rdata_i[{rel[LS-1:0], 3'b000} +: 8];
    end

    assign line_o[i*8 +: 8] = (IDX < op_b_i) ? byte_q : 8'h00;
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int AW   = 32,
  parameter int WS_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_valid_i,
  input  logic                cfg_aa_en_i,
  input  logic [WS_W-1:0]     cfg_ws_i,
  input  logic                req_i,
  input  logic                req_wr_i,
  input  logic [1:0]          req_size_i,
  input  logic [1:0]          req_port_i,
  input  logic                req_burst_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [LINE_B*8-1:0] req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [LINE_B*8-1:0] done_rdata_o,
  output logic                bus_cs_no,
  output logic [AW-1:0]       bus_addr_o,
  output logic [1:0]          bus_tsiz_o,
  output logic                bus_tbst_no,
  output logic [PORT_B*8-1:0] bus_wdata_o,
  output logic                bus_wdata_oe_o,
  input  logic [PORT_B*8-1:0] bus_rdata_i,
  input  logic                bus_ta_ni
);
  xbus_st_e            st_q;
  logic [AW-1:0]       base_q;
  logic                wr_q, burst_q, done_q;
  logic [1:0]          size_q, port_q;
  logic [LINE_B*8-1:0] wline_q;
  logic [BEAT_W-1:0]   beat_q;

  logic                accept, in_beat, ack, last, burst_on;
  logic [1:0]          tsiz;
  logic [AW-1:0]       addr;
  logic [OFF_W-1:0]    off;
  logic [LANE_W-1:0]   lane_b;
  logic [OP_W-1:0]     op_b;

  assign accept  = (st_q == ST_IDLE) && req_i && cfg_valid_i;
  assign in_beat = (st_q == ST_BEAT);

  xbus_beat_plan #(.AW(AW)) u_plan (
    .base_i(base_q), .size_i(size_q), .port_i(port_q), .burst_i(burst_q),
    .beat_i(beat_q), .last_o(last), .burst_on_o(burst_on), .tsiz_o(tsiz),
    .addr_o(addr), .off_o(off), .lane_b_o(lane_b), .op_b_o(op_b)
  );

  xbus_wait_timer #(.WS_W(WS_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .beat_i(in_beat), .aa_en_i(cfg_aa_en_i),
    .ws_i(cfg_ws_i), .ta_ni(bus_ta_ni), .ack_o(ack)
  );

  xbus_data_path u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .cap_i(ack && !wr_q),
    .wline_i(wline_q), .off_i(off), .lane_b_i(lane_b), .op_b_i(op_b),
    .rdata_i(bus_rdata_i), .wdata_o(bus_wdata_o), .line_o(done_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      size_q  <= SZ_LONG;
      port_q  <= 2'b00;
      wline_q <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_BEAT;
          base_q  <= req_addr_i;
          wr_q    <= req_wr_i;
          burst_q <= req_burst_i;
          size_q  <= req_size_i;
          port_q  <= req_port_i;
          wline_q <= req_wdata_i;
          beat_q  <= '0;
        end
        ST_BEAT: if (ack) begin
          if (last) begin
            st_q   <= wr_q ? ST_HOLD : ST_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (st_q != ST_IDLE);
  assign done_o         = done_q;
  assign bus_cs_no      = !in_beat;
  assign bus_addr_o     = in_beat ? addr : '0;
  assign bus_tsiz_o     = in_beat ? tsiz : 2'b00;
  assign bus_tbst_no    = !(in_beat && burst_on);
  // data stays on the bus one clock past chip select
  assign bus_wdata_oe_o = wr_q && (in_beat || st_q == ST_HOLD);
endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       bus_cs_no,
  input logic [1:0] bus_tsiz_o,
  input logic       bus_tbst_no,
  input logic       bus_wdata_oe_o
);
  AST_DONE_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_cs_no && $past(!bus_cs_no))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_TBST_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_tbst_no |-> !bus_cs_no); // R4
  AST_TSIZ_BURST_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_tbst_no && $past(!bus_tbst_no)) |-> $stable(bus_tsiz_o)); // R4
  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wdata_oe_o |-> (!bus_cs_no || $past(!bus_cs_no))); // R10
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bus_wdata_oe_o) |=> !bus_wdata_oe_o); // R10
  AST_INVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_valid_i && !busy_o) |=> !busy_o); // R11
endmodule

bind xbus_master xbus_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i), .busy_o(busy_o),
  .done_o(done_o), .bus_cs_no(bus_cs_no), .bus_tsiz_o(bus_tsiz_o),
  .bus_tbst_no(bus_tbst_no), .bus_wdata_oe_o(bus_wdata_oe_o)
);

// File: tb/xbus_master_bench.sv
module xbus_master_bench;
  typedef struct {
    logic [31:0] a;
    logic [1:0]  tz;
    logic        tb;
    logic [31:0] wd;
    logic        wr;
    string       tag;
  } beat_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_valid_i = 1'b1, cfg_aa_en_i = 1'b0;
  logic [3:0]   cfg_ws_i = '0;
  logic         req_i = 1'b0, req_wr_i = 1'b0, req_burst_i = 1'b0;
  logic [1:0]   req_size_i = '0, req_port_i = '0;
  logic [31:0]  req_addr_i = '0;
  logic [127:0] req_wdata_i = '0;
  logic         busy_o, done_o, bus_cs_no, bus_tbst_no, bus_wdata_oe_o;
  logic [127:0] done_rdata_o;
  logic [31:0]  bus_addr_o, bus_wdata_o;
  logic [1:0]   bus_tsiz_o;
  logic [31:0]  bus_rdata_i = '0;
  logic         bus_ta_ni = 1'b1;

  int checks = 0, failures = 0;
  beat_t        bq[$];
  logic [127:0] rq[$];
  logic         rq_wr[$];
  int  ext_dly = -1;
  int  cyc = 0;
  bit  stray = 0, exp_done = 0, oe_rel = 0;

  always #4 clk_i = ~clk_i;

  xbus_master u_xbus_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [31:0] a);
    mem = a[7:0] * 8'd7 + 8'h3C;
  endfunction

  function automatic int obytes(input logic [1:0] c);
    case (c) 2'b01: return 1; 2'b10: return 2; 2'b11: return 16; default: return 4; endcase
  endfunction

  function automatic int pbytes(input logic [1:0] c);
    case (c) 2'b01: return 1; 2'b10: return 2; default: return 4; endcase
  endfunction

  // monitor and responder: samples between edges, sets ack/read data for the next edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      bus_ta_ni = 1'b1;
      cyc = 0;
    end else begin
      if (oe_rel) begin
        chk(!bus_wdata_oe_o && !done_o, "R10 oe release", {bus_wdata_oe_o, done_o}, 0);
        oe_rel = 0;
      end
      if (exp_done) begin
        logic [127:0] e; logic w;
        e = rq.pop_front(); w = rq_wr.pop_front();
        chk(done_o && bus_cs_no, "R9 done/cs", {done_o, bus_cs_no}, 2'b11);
        if (w) begin
          chk(bus_wdata_oe_o, "R10 oe hold", bus_wdata_oe_o, 1);
          oe_rel = 1;
        end else begin
          chk(done_rdata_o == e, "R8 rdata", done_rdata_o, e);
        end
        exp_done = 0;
      end else if (done_o) begin
        chk(0, "R9 unexpected done", done_o, 0);
      end
      if (!bus_cs_no) begin
        if (bq.size() == 0) begin
          chk(0, "R11 cs without request", bus_cs_no, 1);
          bus_ta_ni = 1'b1;
        end else begin
          beat_t e;
          bit ack;
          e = bq[0];
          bus_ta_ni = !(ext_dly == cyc);
          for (int j = 0; j < 4; j++) bus_rdata_i[j*8 +: 8] = mem(bus_addr_o + 32'(j));
          chk(bus_addr_o == e.a, {e.tag, " R2 addr"}, bus_addr_o, e.a);
          chk(bus_tsiz_o == e.tz, e.tb ? {e.tag, " R3 tsiz"} : {e.tag, " R4 tsiz"}, bus_tsiz_o, e.tz);
          chk(bus_tbst_no == e.tb, {e.tag, " R4 tbst"}, bus_tbst_no, e.tb);
          if (e.wr) begin
            chk(bus_wdata_o == e.wd, {e.tag, " R10 wdata"}, bus_wdata_o, e.wd);
            chk(bus_wdata_oe_o, {e.tag, " R10 oe"}, bus_wdata_oe_o, 1);
          end
          ack = !bus_ta_ni || (cfg_aa_en_i && cyc == int'(cfg_ws_i));
          if (ack) begin
            void'(bq.pop_front());
            cyc = 0;
            if (bq.size() == 0) exp_done = 1;
          end else begin
            cyc++;
          end
        end
      end else begin
        bus_ta_ni = !stray;
        cyc = 0;
      end
    end
  end

  task automatic xfer(input string tag, input logic wr, input logic [1:0] sz, input logic [1:0] pt,
                      input logic bst, input logic [31:0] ad, input logic [127:0] wl,
                      input logic aa, input logic [3:0] ws, input int dly);
    int ob, pb, nb, lb, off, n;
    bit bon;
    logic [31:0] mask, s;
    logic [127:0] rexp;
    beat_t b;
    ob = obytes(sz); pb = pbytes(pt);
    nb = (ob > pb) ? ob / pb : 1;
    lb = (ob < pb) ? ob : pb;
    bon = bst && nb > 1;
    mask = 32'(ob - 1);
    @(negedge clk_i);
    cfg_aa_en_i = aa; cfg_ws_i = ws; ext_dly = dly;
    for (int k = 0; k < nb; k++) begin
      s = ad + 32'(k * pb);
      off = int'(s & mask);
      b.a = (ad & ~mask) | (s & mask);
      b.tz = (bon || k == 0) ? sz : ((pt == 2'b11) ? 2'b00 : pt);
      b.tb = !bon;
      b.wr = wr;
      b.tag = tag;
      b.wd = '0;
      for (int j = 0; j < lb; j++) b.wd[j*8 +: 8] = wl[(off + j)*8 +: 8];
      bq.push_back(b);
    end
    rexp = '0;
    for (int o = 0; o < ob; o++) rexp[o*8 +: 8] = mem((ad & ~mask) + 32'(o));
    rq.push_back(rexp); rq_wr.push_back(wr);
    req_i = 1; req_wr_i = wr; req_size_i = sz; req_port_i = pt; req_burst_i = bst;
    req_addr_i = ad; req_wdata_i = wl;
    @(negedge clk_i);
    req_i = 0;
    n = 0;
    while ((bq.size() > 0 || exp_done || oe_rel) && n < 400) begin
      @(negedge clk_i);
      n++;
    end
    if (n >= 400) begin
      chk(0, {tag, " timeout"}, bq.size(), 0);
      bq.delete(); rq.delete(); rq_wr.delete(); exp_done = 0; oe_rel = 0;
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    for (int i = 0; i < 16; i++) pat[i*8 +: 8] = 8'h10 + 8'(i * 17);
    repeat (3) @(negedge clk_i);
    chk(bus_cs_no && bus_tbst_no && !bus_wdata_oe_o && !busy_o && !done_o,
        "R1 reset outputs", {bus_cs_no, bus_tbst_no, bus_wdata_oe_o, busy_o, done_o}, 5'b11000);
    rst_ni = 1;
    @(negedge clk_i);

    // R7: stray external ack while idle
    stray = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(bus_cs_no && !busy_o && !done_o, "R7 stray ack", {bus_cs_no, busy_o, done_o}, 3'b100);
    end
    stray = 0;
    @(negedge clk_i);

    xfer("R3 long wr 8b single",  1, 2'b00, 2'b01, 0, 32'h0000_0100, pat, 1, 4'd1, -1);
    xfer("R4 long wr 8b burst",   1, 2'b00, 2'b01, 1, 32'h0000_0200, pat, 1, 4'd0, -1);
    xfer("R5 line rd 32b wrap",   0, 2'b11, 2'b00, 1, 32'h0000_1008, pat, 0, 4'd0, 2);
    xfer("R6 line rd 16b early",  0, 2'b11, 2'b10, 0, 32'h0000_2006, pat, 1, 4'd6, 2);
    xfer("R6 half rd 8b ws0",     0, 2'b10, 2'b01, 0, 32'h0000_3002, pat, 1, 4'd0, -1);
    xfer("R4 byte wr 32b single", 1, 2'b01, 2'b00, 1, 32'h0000_4003, pat, 0, 4'd0, 0);
    xfer("R2 long rd 32b ws3",    0, 2'b00, 2'b11, 0, 32'h0000_5004, pat, 1, 4'd3, -1);
    xfer("R2 line wr 8b burst",   1, 2'b11, 2'b01, 1, 32'h0000_600C, pat, 1, 4'd2, 1);
    xfer("R8 line rd 8b single",  0, 2'b11, 2'b01, 0, 32'h0000_7005, pat, 0, 4'd0, 0);

    // R11: region disabled, request must be dropped
    @(negedge clk_i);
    cfg_valid_i = 0;
    req_i = 1; req_wr_i = 0; req_size_i = 2'b00; req_port_i = 2'b00; req_addr_i = 32'h8000;
    @(negedge clk_i);
    req_i = 0;
    for (int i = 0; i < 6; i++) begin
      chk(bus_cs_no && !busy_o, "R11 disabled region", {bus_cs_no, busy_o}, 2'b10);
      @(negedge clk_i);
    end
    cfg_valid_i = 1;
    xfer("R11 after enable",      0, 2'b00, 2'b10, 0, 32'h0000_9000, pat, 1, 4'd1, -1);

    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule